// File: doc/BRIEF.md
# Data Watchpoint Address Matcher

This block is a bank of programmable data watchpoint comparators for a processor debug unit. Each slot holds a control word and a base-address word. Both are loaded through a single-cycle register-write port that takes a slot index, a word select and the data. On every memory access, the block compares the access address, the load/store direction and the privilege level against all slots in parallel. One clock later it reports whether any slot hit, and which slot.

A slot can match in two ways. In byte mode it matches individual bytes of one 8-byte-aligned doubleword, using a contiguous byte-select run. In region mode it matches a naturally aligned power-of-two region, using a count of low address bits to ignore. Each slot also has an access-direction filter and a privilege filter. Misprogrammed slots never match. This covers a reserved mask count, a byte-select run with gaps, and a region whose byte-select is not full.

Top module: `wp_addr_matcher`

## Requirements
- R1: Control bit 0 enables a slot; a slot whose enable bit is 0 never matches.
- R2: Control bits [4:3] filter the access direction (acc_store=1 means store): 01 matches loads only, 10 stores only, 11 both, 00 nothing.
- R3: Control bits [2:1] filter privilege (acc_priv=1 means privileged): 01 matches privileged accesses only, 10 unprivileged only, 11 both, 00 nothing.
- R4: With mask count 0, a slot matches when address bits above bit 2 equal the same bits of the base word and bit N of the byte-select field (control bits [12:5]) is set, where N is address bits [2:0]; base bits [2:0] are ignored.
- R5: A byte-select field that is zero or whose set bits do not form one contiguous run makes the slot never match.
- R6: With mask count M (control bits [28:24]) of 3 or more, a slot matches when the address and base agree on every bit from M upward, so the region is [base, base+2^M) for an aligned base; the byte-select field must then be 0xFF, otherwise the slot never matches.
- R7: Mask counts 1 and 2 are reserved and make the slot never match.
- R8: When cfg_we is high, cfg_wdata is written to slot cfg_idx: to the control word (low 32 bits) when cfg_sel=0, to the base word when cfg_sel=1. An access in the same cycle still sees the old contents, and the new contents apply from the next cycle.
- R9: When several slots match, hit_idx reports the lowest-numbered one.
- R10: hit and hit_idx are registered and reflect the access presented in the previous cycle; a cycle without acc_valid yields hit=0 and hit_idx=0.
- R11: Synchronous reset clears every control and base word and drives hit and hit_idx to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Slot word write strobe |
| cfg_idx | input | IDX_W (2) | Slot to write |
| cfg_sel | input | 1 | 0 = control word, 1 = base word |
| cfg_wdata | input | ADDR_W (48) | Write data |
| acc_valid | input | 1 | Access strobe |
| acc_addr | input | ADDR_W (48) | Access byte address |
| acc_store | input | 1 | 1 = store, 0 = load |
| acc_priv | input | 1 | 1 = privileged, 0 = unprivileged |
| hit | output | 1 | A slot matched the previous access |
| hit_idx | output | IDX_W (2) | Lowest matching slot |

## Verification
The bench aims at the top byte of a masked region and the first byte beyond it. A design with an inclusive upper bound would report a hit one byte past the region. It uses a byte just outside the select run, and a byte in the same lane of the next doubleword. A matcher that ignored the base's doubleword bits would hit on the wrong doubleword. It also covers overlapping slots, where a wrong priority order reports the higher index, and reserved or gapped programming, which a lenient design would still match. A write in the same cycle as an access catches a design that bypasses new configuration into the compare.

// File: rtl/wp_pkg.sv
package wp_pkg;

  localparam int CTRL_W  = 32;
  localparam int BYTES_W = 8;
  localparam int MCNT_W  = 5;

  localparam int EN_POS   = 0;
  localparam int PRIV_LO  = 1;
  localparam int DIR_LO   = 3;
  localparam int BSEL_LO  = 5;
  localparam int MCNT_LO  = 24;

  typedef struct packed {
    logic [MCNT_W-1:0]  mcnt;
    logic [BYTES_W-1:0] bsel;
    logic [1:0]         dir;
    logic [1:0]         priv;
    logic               en;
  } slot_ctrl_t;

  function automatic slot_ctrl_t unpack_ctrl(input logic [CTRL_W-1:0] w);
    slot_ctrl_t c;
    c.en   = w[EN_POS];
    c.priv = w[PRIV_LO +: 2];
    c.dir  = w[DIR_LO +: 2];
    c.bsel = w[BSEL_LO +: BYTES_W];
    c.mcnt = w[MCNT_LO +: MCNT_W];
    return c;
  endfunction

endpackage

// File: rtl/wp_cfg_bank.sv
module wp_cfg_bank
  import wp_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 48,
  localparam int IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output slot_ctrl_t        ctrl_q [NUM_SLOTS],
  output logic [ADDR_W-1:0] base_q [NUM_SLOTS]
);

  slot_ctrl_t ctrl_in;
  assign ctrl_in = unpack_ctrl(cfg_wdata[CTRL_W-1:0]);

  logic unused_cfg_bits;
  assign unused_cfg_bits = ^{cfg_wdata[CTRL_W-1:MCNT_LO+MCNT_W],
                             cfg_wdata[MCNT_LO-1:BSEL_LO+BYTES_W]};

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic sel_slot;
    assign sel_slot = cfg_we && (cfg_idx == IDX_W'(s));

    always_ff @(posedge clk) begin
      if (rst) begin
        ctrl_q[s] <= '0;
        base_q[s] <= '0;
      end else if (sel_slot) begin
        if (cfg_sel) base_q[s] <= cfg_wdata;
        else         ctrl_q[s] <= ctrl_in;
      end
    end
  end

endmodule

// File: rtl/wp_slot_cmp.sv
module wp_slot_cmp
  import wp_pkg::*;
#(
  parameter int ADDR_W = 48
) (
  input  slot_ctrl_t        ctrl,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_store,
  input  logic              acc_priv,
  output logic              match
);

  localparam int LANE_W = $clog2(BYTES_W);

  logic              dir_ok, priv_ok;
  logic [ADDR_W-1:0] diff;
  logic              dw_eq, region_eq;
  logic [BYTES_W-1:0] low_bit;
  logic [BYTES_W:0]   run_sum;
  logic              bsel_contig, bsel_full, lane_sel;
  logic              mcnt_reserved, mcnt_zero;
  logic [LANE_W-1:0] lane;

  assign dir_ok  = acc_store ? ctrl.dir[1]  : ctrl.dir[0];
  assign priv_ok = acc_priv  ? ctrl.priv[0] : ctrl.priv[1];

  assign diff      = acc_addr ^ base;
  assign dw_eq     = (diff[ADDR_W-1:LANE_W] == '0);
  assign region_eq = ((diff >> ctrl.mcnt) == '0);

  // contiguity: adding the lowest set bit must clear the whole run
  assign low_bit     = ctrl.bsel & (~ctrl.bsel + BYTES_W'(1));
  assign run_sum     = {1'b0, ctrl.bsel} + {1'b0, low_bit};
  assign bsel_contig = (ctrl.bsel != '0) && ((run_sum[BYTES_W-1:0] & ctrl.bsel) == '0);
  assign bsel_full   = &ctrl.bsel;

  assign lane     = acc_addr[LANE_W-1:0];
  assign lane_sel = ctrl.bsel[lane];

  assign mcnt_zero     = (ctrl.mcnt == '0);
  assign mcnt_reserved = (ctrl.mcnt == MCNT_W'(1)) || (ctrl.mcnt == MCNT_W'(2));

  always_comb begin
    match = 1'b0;
    if (ctrl.en && dir_ok && priv_ok && bsel_contig && !mcnt_reserved) begin
      if (mcnt_zero) match = dw_eq && lane_sel;
      else           match = bsel_full && region_eq;
    end
  end

endmodule

// File: rtl/wp_first_hit.sv
module wp_first_hit #(
  parameter int NUM_SLOTS = 4,
  localparam int IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic [NUM_SLOTS-1:0] req,
  output logic                 any,
  output logic [IDX_W-1:0]     idx
);

  always_comb begin
    any = |req;
    idx = '0;
    for (int k = NUM_SLOTS - 1; k >= 0; k--) begin
      if (req[k]) idx = IDX_W'(k);
    end
  end

endmodule

// File: rtl/wp_addr_matcher.sv
module wp_addr_matcher
  import wp_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 48,
  localparam int IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_store,
  input  logic              acc_priv,
  output logic              hit,
  output logic [IDX_W-1:0]  hit_idx
);

  slot_ctrl_t             ctrl_q [NUM_SLOTS];
  logic [ADDR_W-1:0]      base_q [NUM_SLOTS];
  logic [NUM_SLOTS-1:0]   slot_match;
  logic                   any_match;
  logic [IDX_W-1:0]       first_idx;

  wp_cfg_bank #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W)) u_bank (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .ctrl_q(ctrl_q), .base_q(base_q)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_cmp
    wp_slot_cmp #(.ADDR_W(ADDR_W)) u_cmp (
      .ctrl(ctrl_q[s]), .base(base_q[s]), .acc_addr(acc_addr),
      .acc_store(acc_store), .acc_priv(acc_priv), .match(slot_match[s])
    );
  end

  wp_first_hit #(.NUM_SLOTS(NUM_SLOTS)) u_pick (
    .req(slot_match), .any(any_match), .idx(first_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hit     <= 1'b0;
      hit_idx <= '0;
    end else if (acc_valid && any_match) begin
      hit     <= 1'b1;
      hit_idx <= first_idx;
    end else begin
      hit     <= 1'b0;
      hit_idx <= '0;
    end
  end

  // R10: a hit only follows a cycle carrying an access
  a_r10_hit_after_valid: assert property (@(posedge clk) disable iff (rst)
    hit |-> $past(acc_valid));

  // R11: reset leaves outputs idle
  a_r11_reset_idle: assert property (@(posedge clk)
    $past(rst) |-> (!hit && hit_idx == '0));

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_chk
    // R1: reported slot was enabled
    a_r1_enabled: assert property (@(posedge clk) disable iff (rst)
      (hit && hit_idx == IDX_W'(s)) |-> $past(ctrl_q[s].en));
    // R2: direction filter admitted the access
    a_r2_dir: assert property (@(posedge clk) disable iff (rst)
      (hit && hit_idx == IDX_W'(s)) |->
        $past(acc_store ? ctrl_q[s].dir[1] : ctrl_q[s].dir[0]));
    // R3: privilege filter admitted the access
    a_r3_priv: assert property (@(posedge clk) disable iff (rst)
      (hit && hit_idx == IDX_W'(s)) |->
        $past(acc_priv ? ctrl_q[s].priv[0] : ctrl_q[s].priv[1]));
    // R7: reserved mask counts never report
    a_r7_reserved: assert property (@(posedge clk) disable iff (rst)
      (hit && hit_idx == IDX_W'(s)) |->
        !$past(ctrl_q[s].mcnt == MCNT_W'(1) || ctrl_q[s].mcnt == MCNT_W'(2)));
    // R9: no lower slot was matching
    if (s > 0) begin : g_lower
      a_r9_lowest: assert property (@(posedge clk) disable iff (rst)
        (hit && hit_idx == IDX_W'(s)) |-> $past(slot_match[s-1:0] == '0));
    end
  end

endmodule

// File: tb/test_wp_addr_matcher.sv
`timescale 1ns/1ps
module test_wp_addr_matcher;

  localparam int AW = 48;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_idx = '0;
  logic          cfg_sel = 1'b0;
  logic [AW-1:0] cfg_wdata = '0;
  logic          acc_valid = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic          acc_store = 1'b0;
  logic          acc_priv = 1'b0;
  logic          hit;
  logic [1:0]    hit_idx;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  wp_addr_matcher #(.NUM_SLOTS(4), .ADDR_W(AW)) i_wp_addr_matcher (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_store(acc_store), .acc_priv(acc_priv),
    .hit(hit), .hit_idx(hit_idx)
  );

  typedef struct packed {
    logic [AW-1:0] addr;
    logic          st;
    logic          pv;
    logic          eh;
    logic [1:0]    ei;
  } vec_t;

  // slot0: load, both priv, bytes 2..5 @0x1000; slot1: store, 16B @0x2000
  // slot2: both dirs, privileged only, byte 0 @0x1000; slot3: any, 4KB @0x1000
  localparam vec_t VECS [12] = '{
    '{48'h1002, 1'b0, 1'b1, 1'b1, 2'd0},
    '{48'h1002, 1'b1, 1'b1, 1'b1, 2'd3},
    '{48'h1000, 1'b0, 1'b1, 1'b1, 2'd2},
    '{48'h1000, 1'b0, 1'b0, 1'b1, 2'd3},
    '{48'h1006, 1'b0, 1'b0, 1'b1, 2'd3},
    '{48'h1005, 1'b0, 1'b0, 1'b1, 2'd0},
    '{48'h200F, 1'b1, 1'b0, 1'b1, 2'd1},
    '{48'h2010, 1'b1, 1'b0, 1'b0, 2'd0},
    '{48'h2008, 1'b0, 1'b1, 1'b0, 2'd0},
    '{48'h1FFF, 1'b1, 1'b0, 1'b1, 2'd3},
    '{48'h0FFF, 1'b0, 1'b1, 1'b0, 2'd0},
    '{48'h1008, 1'b0, 1'b1, 1'b1, 2'd3}
  };

  task automatic check(input string req, input logic eh, input logic [1:0] ei);
    n_run++;
    if (hit !== eh || (eh && hit_idx !== ei) || (!eh && hit_idx !== 2'd0)) begin
      n_fail++;
      $display("FAIL %s: hit=%0b idx=%0d expected hit=%0b idx=%0d",
               req, hit, hit_idx, eh, eh ? ei : 2'd0);
    end
  endtask

  task automatic wr(input int idx, input bit sel, input logic [AW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx[1:0]; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic acc(input logic [AW-1:0] a, input logic st, input logic pv,
                     input string req, input logic eh, input logic [1:0] ei);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_store = st; acc_priv = pv;
    @(negedge clk);
    acc_valid = 1'b0;
    check(req, eh, ei);
  endtask

  task automatic program_all();
    wr(0, 1'b0, 48'h0000_0000_078F); wr(0, 1'b1, 48'h1000);
    wr(1, 1'b0, 48'h0000_0400_1FF7); wr(1, 1'b1, 48'h2000);
    wr(2, 1'b0, 48'h0000_0000_003B); wr(2, 1'b1, 48'h1000);
    wr(3, 1'b0, 48'h0000_0C00_1FFF); wr(3, 1'b1, 48'h1000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R11 reset outputs", 1'b0, 2'd0);
    acc(48'h0, 1'b0, 1'b1, "R11 cleared slots", 1'b0, 2'd0);

    program_all();
    for (int v = 0; v < 12; v++) begin
      acc(VECS[v].addr, VECS[v].st, VECS[v].pv,
          "R2 R3 R4 R6 R9 table", VECS[v].eh, VECS[v].ei);
    end

    // R10: no strobe, no hit
    @(negedge clk);
    acc_valid = 1'b0; acc_addr = 48'h1002; acc_store = 1'b0; acc_priv = 1'b1;
    @(negedge clk);
    check("R10 idle cycle", 1'b0, 2'd0);

    // R1: disabling slot3 removes its hits
    wr(3, 1'b0, 48'h0000_0C00_1FFE);
    acc(48'h1800, 1'b0, 1'b1, "R1 disabled slot", 1'b0, 2'd0);

    // R5: gapped select 0x24
    wr(0, 1'b0, 48'h0000_0000_048F);
    acc(48'h1002, 1'b0, 1'b1, "R5 gapped select", 1'b0, 2'd0);

    // R6: region with partial select
    wr(1, 1'b0, 48'h0000_0400_01F7);
    acc(48'h2000, 1'b1, 1'b0, "R6 partial select region", 1'b0, 2'd0);

    // R7: reserved mask count 2
    wr(1, 1'b0, 48'h0000_0200_1FF7);
    acc(48'h2000, 1'b1, 1'b0, "R7 reserved mask", 1'b0, 2'd0);

    // R3: privilege field 00
    wr(2, 1'b0, 48'h0000_0000_0039);
    acc(48'h1000, 1'b0, 1'b1, "R3 privilege none", 1'b0, 2'd0);

    // R2: direction field 00
    wr(2, 1'b0, 48'h0000_0000_0027);
    acc(48'h1000, 1'b0, 1'b1, "R2 direction none", 1'b0, 2'd0);

    // R8: same-cycle write is not yet visible
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 2'd2; cfg_sel = 1'b0; cfg_wdata = 48'h3B;
    acc_valid = 1'b1; acc_addr = 48'h1000; acc_store = 1'b0; acc_priv = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    check("R8 old contents same cycle", 1'b0, 2'd0);
    @(negedge clk);
    acc_valid = 1'b0;
    check("R8 new contents next cycle", 1'b1, 2'd2);

    // R11: reset in mid-run clears programmed slots
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    acc(48'h1000, 1'b0, 1'b1, "R11 mid-run reset", 1'b0, 2'd0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule